// File: doc/BRIEF.md
# Timer Run and External Interrupt Control Register

This block is one 8-bit control and status register inside a small microcontroller core. It holds a run enable for each of two timers and an overflow flag for each. For each of two external interrupt inputs it also holds a trigger-type select and a pending flag. The CPU reaches the register in three ways: a byte write port, a single-bit write port using bit addresses, and a read port. Next to it sit the timers, which send overflow pulses, the two external pins with a polarity bit per pin, and the vectoring logic, which sends an acknowledge strobe per source when it enters that source's handler.

The flags drive four interrupt request lines directly. A timer flag is set by its overflow and cleared by software or by its acknowledge. An external flag depends on its type bit. In edge mode it latches an active edge of the synchronized pin and is cleared by software or by acknowledge. In level mode it follows the active level of the pin, and writes and acknowledges leave it alone. A hardware set always beats a clear in the same cycle, so a read-modify-write of other bits cannot lose an event.

Top module: `tmr_xint_ctl`

## Requirements
- R1: After reset the register reads 0x00, and tmr_run, irq_tmr and irq_xint are all zero.
- R2: A byte write with wr_addr equal to 0x88 loads the register at the next clock edge. A byte write to any other address changes nothing. The bit layout from bit 7 down to bit 0 is: timer 1 flag, timer 1 run, timer 0 flag, timer 0 run, ext 1 flag, ext 1 type, ext 0 flag, ext 0 type.
- R3: A bit write to bit address 0x88+n (n = 0..7) changes only bit n at the next edge. A bit write to an address outside 0x88..0x8F changes nothing.
- R4: rd_data equals the register contents in the same cycle while rd_addr is 0x88, and is 0x00 for any other rd_addr.
- R5: A tmr_ovf[i] pulse sets timer i's flag at the next edge, and irq_tmr[i] follows the flag.
- R6: The timer i flag clears at the next edge on ack_tmr[i]. Software writes can also clear or set it.
- R7: A hardware set of a flag in the same cycle as a software clear or an acknowledge leaves the flag set.
- R8: With the type bit at 1 (edge mode), an active edge on xint_pin[i] sets ext flag i three edges after the pin changes: two synchronizer stages plus the flag register. The flag stays set after the pin returns, and it clears on ack_xint[i] or on a software write of 0.
- R9: With the type bit at 0 (level mode), ext flag i equals the active level of the pin delayed by three edges. Software writes and ack_xint[i] have no effect on that flag.
- R10: xint_pol[i] = 1 makes the high level and the rising edge active. xint_pol[i] = 0 makes the low level and the falling edge active.
- R11: tmr_run[1] and tmr_run[0] equal register bits 6 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte write address |
| wr_data | input | 8 | Byte write data |
| bit_wr_en | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address for single-bit write |
| bit_val | input | 1 | Value for single-bit write |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data |
| tmr_ovf | input | 2 | Timer overflow pulses |
| xint_pin | input | 2 | External interrupt pins (asynchronous) |
| xint_pol | input | 2 | Active level per pin, 1 = high |
| ack_tmr | input | 2 | Vector acknowledge per timer |
| ack_xint | input | 2 | Vector acknowledge per external input |
| reg_value | output | 8 | Register contents |
| tmr_run | output | 2 | Timer run enables |
| irq_tmr | output | 2 | Timer interrupt requests |
| irq_xint | output | 2 | External interrupt requests |

## Verification
Writes, overflow pulses and acknowledges show in the register one rising edge after they are presented. A pin change shows in the ext flag on the third rising edge, and rd_data follows rd_addr in the same cycle. The bench drives inputs 1 ns after a rising edge and advances its reference model on each rising edge. It compares every output at the falling edge, so each registered result is sampled in the cycle it falls due. Directed checks count steps of whole cycles: one step for write, overflow and acknowledge effects, three steps for pin effects.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;

    localparam int REG_W   = 8;
    localparam int NUM_SRC = 2;

    // Bit positions of the fields for source i (0 or 1).
    function automatic int pos_xtype(int i); return 2 * i;     endfunction
    function automatic int pos_xflag(int i); return 2 * i + 1; endfunction
    function automatic int pos_trun(int i);  return 2 * i + 4; endfunction
    function automatic int pos_tflag(int i); return 2 * i + 5; endfunction

    typedef struct packed {
        logic [NUM_SRC-1:0] tflag;
        logic [NUM_SRC-1:0] trun;
        logic [NUM_SRC-1:0] xflag;
        logic [NUM_SRC-1:0] xtype;
    } ctl_state_t;

    function automatic logic [REG_W-1:0] pack_reg(ctl_state_t s);
        logic [REG_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            r[pos_tflag(i)] = s.tflag[i];
            r[pos_trun(i)]  = s.trun[i];
            r[pos_xflag(i)] = s.xflag[i];
            r[pos_xtype(i)] = s.xtype[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/xint_front.sv
module xint_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic active_high,
    output logic active,
    output logic edge_hit
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } front_t;

    front_t front_d, front_q;

    always_comb begin
        front_d      = front_q;
        front_d.sync = {front_q.sync[STAGES-2:0], pin};
        active       = active_high ? front_q.sync[STAGES-1] : ~front_q.sync[STAGES-1];
        edge_hit     = active & ~front_q.prev;
        front_d.prev = active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            front_q.sync <= '0;
            front_q.prev <= 1'b1;
        end else begin
            front_q <= front_d;
        end
    end

    // R8: an edge detection is a single-cycle event
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> !edge_hit);

endmodule

// File: rtl/ctl_wr_decode.sv
module ctl_wr_decode
    import tmr_xint_pkg::*;
#(
    parameter logic [7:0] REG_ADDR = 8'h88
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             bit_wr_en,
    input  logic [7:0]       bit_addr,
    input  logic             bit_val,
    output logic [REG_W-1:0] sw_we,
    output logic [REG_W-1:0] sw_val
);

    logic byte_hit, bit_hit;

    always_comb begin
        byte_hit = wr_en && (wr_addr == REG_ADDR);
        bit_hit  = bit_wr_en && (bit_addr[7:3] == REG_ADDR[7:3]);
        for (int b = 0; b < REG_W; b++) begin
            sw_we[b]  = byte_hit;
            sw_val[b] = wr_data[b];
            if (bit_hit && (bit_addr[2:0] == 3'(b))) begin
                sw_we[b]  = 1'b1;
                sw_val[b] = bit_val;
            end
        end
    end

    // R3: a lone bit write touches at most one bit
    a_r3_one_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr_en && !wr_en) |-> ($countones(sw_we) <= 1));

endmodule

// File: rtl/tmr_xint_ctl.sv
module tmr_xint_ctl
    import tmr_xint_pkg::*;
#(
    parameter logic [7:0] REG_ADDR    = 8'h88,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               bit_wr_en,
    input  logic [7:0]         bit_addr,
    input  logic               bit_val,
    input  logic [7:0]         rd_addr,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_SRC-1:0] tmr_ovf,
    input  logic [NUM_SRC-1:0] xint_pin,
    input  logic [NUM_SRC-1:0] xint_pol,
    input  logic [NUM_SRC-1:0] ack_tmr,
    input  logic [NUM_SRC-1:0] ack_xint,
    output logic [REG_W-1:0]   reg_value,
    output logic [NUM_SRC-1:0] tmr_run,
    output logic [NUM_SRC-1:0] irq_tmr,
    output logic [NUM_SRC-1:0] irq_xint
);

    ctl_state_t         ctl_d, ctl_q;
    logic [REG_W-1:0]   sw_we, sw_val;
    logic [NUM_SRC-1:0] xact, xedge;

    ctl_wr_decode #(.REG_ADDR(REG_ADDR)) u_wr_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .bit_wr_en (bit_wr_en),
        .bit_addr  (bit_addr),
        .bit_val   (bit_val),
        .sw_we     (sw_we),
        .sw_val    (sw_val)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        xint_front #(.STAGES(SYNC_STAGES)) u_front (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin         (xint_pin[g]),
            .active_high (xint_pol[g]),
            .active      (xact[g]),
            .edge_hit    (xedge[g])
        );

        // R5: an overflow always leaves the flag set, whatever else happens
        a_r5_ovf_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_ovf[g] |=> irq_tmr[g]);

        // R6: acknowledge without overflow clears the timer flag
        a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_tmr[g] && !tmr_ovf[g]) |=> !irq_tmr[g]);

        // R9: in level mode the flag mirrors the detector output
        a_r9_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl_q.xtype[g] |=> (irq_xint[g] == $past(xact[g])));
    end

    always_comb begin
        ctl_d = ctl_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sw_we[pos_trun(i)])  ctl_d.trun[i]  = sw_val[pos_trun(i)];
            if (sw_we[pos_xtype(i)]) ctl_d.xtype[i] = sw_val[pos_xtype(i)];

            if (tmr_ovf[i])                ctl_d.tflag[i] = 1'b1;
            else if (ack_tmr[i])           ctl_d.tflag[i] = 1'b0;
            else if (sw_we[pos_tflag(i)])  ctl_d.tflag[i] = sw_val[pos_tflag(i)];

            if (!ctl_q.xtype[i])           ctl_d.xflag[i] = xact[i];
            else if (xedge[i])             ctl_d.xflag[i] = 1'b1;
            else if (ack_xint[i])          ctl_d.xflag[i] = 1'b0;
            else if (sw_we[pos_xflag(i)])  ctl_d.xflag[i] = sw_val[pos_xflag(i)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign reg_value = pack_reg(ctl_q);
    assign rd_data   = (rd_addr == REG_ADDR) ? reg_value : '0;
    assign tmr_run   = ctl_q.trun;
    assign irq_tmr   = ctl_q.tflag;
    assign irq_xint  = ctl_q.xflag;

    // R11: run enables move only on a write
    a_r11_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !bit_wr_en) |=> $stable(tmr_run));

endmodule

// File: tb/tmr_xint_ctl_bench.sv
`timescale 1ns/1ps
module tmr_xint_ctl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, bit_wr_en = 0, bit_val = 0;
    logic [7:0] wr_addr = 0, wr_data = 0, bit_addr = 0, rd_addr = 8'h88;
    logic [1:0] tmr_ovf = 0, xint_pin = 0, xint_pol = 2'b11, ack_tmr = 0, ack_xint = 0;
    logic [7:0] rd_data, reg_value;
    logic [1:0] tmr_run, irq_tmr, irq_xint;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr_xint_ctl u_tmr_xint_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bit_wr_en(bit_wr_en), .bit_addr(bit_addr), .bit_val(bit_val),
        .rd_addr(rd_addr), .rd_data(rd_data), .tmr_ovf(tmr_ovf), .xint_pin(xint_pin),
        .xint_pol(xint_pol), .ack_tmr(ack_tmr), .ack_xint(ack_xint),
        .reg_value(reg_value), .tmr_run(tmr_run), .irq_tmr(irq_tmr), .irq_xint(irq_xint)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced at each rising edge from the requirements
    logic [7:0] m_reg;
    logic [1:0] m_aprev;
    logic [1:0] pin_hist[$];

    always @(posedge clk) begin
        logic [7:0] we, val, nx;
        logic [1:0] an;
        logic a, e;
        if (!rst_n) begin
            m_reg = 8'h00;
            m_aprev = 2'b11;
            pin_hist = {2'b00, 2'b00};
        end else begin
            we = 8'h00; val = 8'h00;
            if (wr_en && wr_addr == 8'h88) begin we = 8'hFF; val = wr_data; end
            if (bit_wr_en && bit_addr >= 8'h88 && bit_addr <= 8'h8F) begin
                we[bit_addr[2:0]] = 1'b1;
                val[bit_addr[2:0]] = bit_val;
            end
            nx = m_reg;
            for (int i = 0; i < 2; i++) begin
                if (we[4+2*i]) nx[4+2*i] = val[4+2*i];
                if (we[2*i])   nx[2*i]   = val[2*i];
                if (tmr_ovf[i])      nx[5+2*i] = 1'b1;
                else if (ack_tmr[i]) nx[5+2*i] = 1'b0;
                else if (we[5+2*i])  nx[5+2*i] = val[5+2*i];
                a = xint_pol[i] ? pin_hist[1][i] : !pin_hist[1][i];
                e = a && !m_aprev[i];
                an[i] = a;
                if (!m_reg[2*i])      nx[1+2*i] = a;
                else if (e)           nx[1+2*i] = 1'b1;
                else if (ack_xint[i]) nx[1+2*i] = 1'b0;
                else if (we[1+2*i])   nx[1+2*i] = val[1+2*i];
            end
            m_reg = nx;
            m_aprev = an;
            pin_hist.push_front(xint_pin);
            void'(pin_hist.pop_back());
        end
    end

    // Compare every output against the model at each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 register", reg_value, m_reg);
            chk("R5 timer irq", irq_tmr, {m_reg[7], m_reg[5]});
            chk("R11 run", tmr_run, {m_reg[6], m_reg[4]});
            chk("R4 read", rd_data, (rd_addr == 8'h88) ? m_reg : 8'h00);
            for (int i = 0; i < 2; i++)
                chk(m_reg[2*i] ? "R8 ext irq edge" : "R9 ext irq level",
                    irq_xint[i], m_reg[1+2*i]);
        end
    end

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            wr_en = 0; bit_wr_en = 0; tmr_ovf = 0; ack_tmr = 0; ack_xint = 0;
        end
    endtask

    task automatic byte_wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
    endtask

    task automatic bit_wr(input logic [7:0] a, input logic v);
        bit_wr_en = 1; bit_addr = a; bit_val = v;
    endtask

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset reg", reg_value, 8'h00);
        chk("R1 reset irq", {tmr_run, irq_tmr, irq_xint}, 0);
        rst_n = 1;
        step(2);
        chk("R1 after release", reg_value, 8'h00);

        byte_wr(8'h88, 8'h55); step();
        chk("R2 byte write", reg_value, 8'h55);
        byte_wr(8'h89, 8'hAA); step();
        chk("R2 foreign address", reg_value, 8'h55);

        bit_wr(8'h8E, 1'b0); step();
        chk("R3 bit6 clear", reg_value, 8'h15);
        bit_wr(8'h8B, 1'b1); step();
        chk("R3 bit3 set", reg_value, 8'h1D);
        bit_wr(8'h90, 1'b1); step();
        chk("R3 outside range", reg_value, 8'h1D);

        tmr_ovf = 2'b10; step();
        chk("R5 overflow sets", irq_tmr, 2'b10);
        ack_tmr = 2'b10; step();
        chk("R6 ack clears", irq_tmr, 2'b00);
        tmr_ovf = 2'b10; ack_tmr = 2'b10; byte_wr(8'h88, 8'h1D); step();
        chk("R7 set wins", reg_value, 8'h9D);
        byte_wr(8'h88, 8'h15); step();
        chk("R6 software clear", reg_value, 8'h15);

        xint_pol = 2'b10; xint_pin = 2'b01; step(4);
        bit_wr(8'h89, 1'b0); step();
        chk("R8 software clear", irq_xint[0], 0);
        xint_pin = 2'b00; step(2);
        chk("R10 falling edge not yet", irq_xint[0], 0);
        step();
        chk("R10 falling edge sets", irq_xint[0], 1);
        xint_pin = 2'b01; step(3);
        chk("R8 flag held", irq_xint[0], 1);
        ack_xint = 2'b01; step();
        chk("R8 ack clears", irq_xint[0], 0);

        bit_wr(8'h88, 1'b0); xint_pol = 2'b11; step(3);
        chk("R9 level active", irq_xint[0], 1);
        bit_wr(8'h89, 1'b0); ack_xint = 2'b01; step();
        chk("R9 write and ack ignored", irq_xint[0], 1);
        xint_pin = 2'b00; step(3);
        chk("R9 level released", irq_xint[0], 0);

        for (int c = 0; c < 4000; c++) begin
            tmr_ovf  = 2'($urandom_range(0, 7) == 0) | (2'($urandom_range(0, 7) == 0) << 1);
            ack_tmr  = 2'($urandom_range(0, 3));
            ack_xint = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
            if ($urandom_range(0, 15) == 0) xint_pin = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 255) == 0) xint_pol = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0)
                byte_wr($urandom_range(0, 1) ? 8'h88 : 8'h8C, 8'($urandom_range(0, 255)));
            if ($urandom_range(0, 7) == 0)
                bit_wr($urandom_range(0, 7) == 0 ? 8'h98 : 8'(8'h88 + $urandom_range(0, 7)),
                       1'($urandom_range(0, 1)));
            rd_addr = ($urandom_range(0, 3) == 0) ? 8'h87 : 8'h88;
            @(posedge clk);
            #1;
            wr_en = 0; bit_wr_en = 0;
        end
        step(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule